// File: doc/BRIEF.md
# Vector Register-Group Slide Unit

This block moves the elements of a vector register group to new positions. A group holds one to eight 128-bit registers, so a vector can be up to 1024 bits long. One offset applies to every element. Element values are copied unchanged and only their positions change. Five operations are available:

- a plain copy;
- a shift toward higher indices by an offset;
- a shift toward lower indices by an offset;
- a shift by one toward higher indices, with a scalar written into the vacated element;
- a shift by one toward lower indices, with a scalar written into the vacated element.

Elements can be 8, 16 or 32 bits wide.

The unit works through a plain register-file interface. It has a combinational read port and a write port with one enable per byte. Destination registers are produced one at a time, lowest first. For each one the unit reads the two source registers that can feed it, then writes the result. Byte enables protect every element the operation must leave alone. After the last write the unit pulses `done` for one cycle.

Top module: `vslide_unit`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `rd_en` are all low. While the unit is idle it neither reads nor writes.
- R2: Op code 1 shifts up by offset k. Destination element i with k <= i < vl takes source element i-k. Destination elements below k keep their previous contents.
- R3: Op code 2 shifts down by offset k. Destination element i < vl takes source element i+k when i+k < vl, and zero otherwise.
- R4: Op code 3 writes the low SEW bits of `scalar` into destination element 0. Every other element 0 < i < vl takes source element i-1.
- R5: Op code 4 writes the low SEW bits of `scalar` into destination element vl-1. Every other element i < vl-1 takes source element i+1.
- R6: Op code 0 copies source element i to destination element i for every i < vl.
- R7: Destination elements at index vl or above are never written. With vl = 0 no byte is written at all.
- R8: The 32-bit offset is clipped to vl. With an offset of vl or more, a shift up leaves the destination unchanged and a shift down zeroes elements 0..vl-1.
- R9: `sew` selects the element width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. Element i occupies the bytes i*w to i*w+w-1 of the group, where w is the width in bytes. Group byte b lies in register base+b/16, in byte lane b%16.
- R10: Let G = `grp_m1`+1 be the group size, and let the start be accepted at a clock edge. `busy` is then high for exactly 3*G cycles. `done` is high for the single cycle that follows. A `start` raised while busy is ignored.
- R11: Writes go to `vd_base`, `vd_base`+1, ... in ascending order. Consecutive writes are three cycles apart and are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op | input | 3 | 0 copy, 1 shift up, 2 shift down, 3 shift up by one with scalar, 4 shift down by one with scalar |
| sew | input | 2 | Element width select (8/16/32) |
| vl | input | 8 | Active element count |
| grp_m1 | input | 3 | Registers in the group minus one |
| offset | input | 32 | Element offset for op codes 1 and 2 |
| scalar | input | 32 | Value inserted by op codes 3 and 4 |
| vs_base | input | 5 | First source register |
| vd_base | input | 5 | First destination register |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | 5 | Read register index |
| rd_data | input | 128 | Read data, valid in the same cycle |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 5 | Write register index |
| wr_be | output | 16 | Per-byte write enable |
| wr_data | output | 128 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle:

- `done` is a single-cycle pulse.
- Writes are never back to back and step through ascending destination registers.
- The idle unit makes no accesses.
- A far shift up enables no byte.
- vl = 0 enables no byte.
- A shift up by one puts the scalar in element 0.

Only the bench scenarios can show that every moved element lands in the right place, across register boundaries, and that zero fill and tail protection behave at all three element widths. The same holds for a late `start` having no effect on the result or on the timing.

// File: rtl/vslide_pkg.sv
package vslide_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_UP    = 3'd1,
        OP_DOWN  = 3'd2,
        OP_UP1   = 3'd3,
        OP_DOWN1 = 3'd4
    } slide_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RDLO,
        PH_RDHI,
        PH_WR,
        PH_FIN
    } phase_e;

endpackage

// File: rtl/vslide_srcsel.sv
// Finds the pair of source registers whose bytes land in destination register r.
module vslide_srcsel #(
    parameter int VB   = 16,
    parameter int GW   = 3,
    parameter int PW   = 9,
    parameter int BOFS = 4
) (
    input  logic [GW-1:0]   r,
    input  logic [GW-1:0]   grp,
    input  logic [PW-1:0]   shb,
    input  logic            up,
    output logic [GW-1:0]   lo_reg,
    output logic [GW-1:0]   hi_reg,
    output logic            lo_ok,
    output logic            hi_ok,
    output logic [BOFS-1:0] rot
);
    logic signed [PW-1:0] base_pos;
    logic signed [PW-1:0] src_pos;
    logic signed [PW-1:0] lo_idx;
    logic signed [PW-1:0] hi_idx;
    logic signed [PW-1:0] last_idx;

    always_comb begin
        base_pos = signed'(PW'(r) * PW'(VB));
        src_pos  = up ? (base_pos - signed'(shb)) : (base_pos + signed'(shb));
        lo_idx   = src_pos >>> BOFS;
        hi_idx   = lo_idx + 1;
        last_idx = signed'(PW'(grp));
        lo_ok    = (lo_idx >= 0) && (lo_idx <= last_idx);
        hi_ok    = (hi_idx >= 0) && (hi_idx <= last_idx);
        lo_reg   = lo_idx[GW-1:0];
        hi_reg   = hi_idx[GW-1:0];
        rot      = src_pos[BOFS-1:0];
    end
endmodule

// File: rtl/vslide_bytemux.sv
// Per-byte result selection and write-enable generation for one destination register.
module vslide_bytemux
    import vslide_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int GW   = 3,
    parameter int PW   = 9,
    parameter int VLW  = 8,
    parameter int XLEN = 32,
    parameter int BOFS = 4
) (
    input  logic [GW-1:0]     r,
    input  logic [VLEN-1:0]   lo,
    input  logic [VLEN-1:0]   hi,
    input  logic [BOFS-1:0]   rot,
    input  slide_op_e         op,
    input  logic [1:0]        sew,
    input  logic [VLW-1:0]    vl,
    input  logic [VLW-1:0]    kc,
    input  logic [XLEN-1:0]   scal,
    output logic [VLEN/8-1:0] be,
    output logic [VLEN-1:0]   data
);
    localparam int VB = VLEN / 8;

    logic [2*VLEN-1:0] window;
    logic [2*VLEN-1:0] moved;
    logic [1:0]        sub_mask;

    always_comb begin
        window   = {hi, lo};
        moved    = window >> {rot, 3'b000};
        sub_mask = (2'b01 << sew) - 2'b01;
    end

    for (genvar j = 0; j < VB; j++) begin : g_byte
        logic [PW-1:0] bpos;
        logic [PW-1:0] eidx;
        logic [1:0]    sub;
        logic          in_body;
        logic          below;
        logic          is_scal;
        logic          fill0;

        always_comb begin
            bpos    = PW'(r) * PW'(VB) + PW'(j);
            eidx    = bpos >> sew;
            sub     = bpos[1:0] & sub_mask;
            in_body = eidx < PW'(vl);
            below   = eidx < PW'(kc);
            is_scal = ((op == OP_UP1) && (eidx == '0)) ||
                      ((op == OP_DOWN1) && (eidx == PW'(vl) - PW'(1)));
            fill0   = (op == OP_DOWN) && ((eidx + PW'(kc)) >= PW'(vl));
            be[j]   = in_body && !((op == OP_UP) && below);
            if (is_scal)
                data[j*8 +: 8] = scal[{sub, 3'b000} +: 8];
            else if (fill0)
                data[j*8 +: 8] = 8'h00;
            else
                data[j*8 +: 8] = moved[j*8 +: 8];
        end
    end
endmodule

// File: rtl/vslide_unit.sv
module vslide_unit
    import vslide_pkg::*;
#(
    parameter int VLEN    = 128,
    parameter int MAX_GRP = 8,
    parameter int XLEN    = 32,
    parameter int RF_AW   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2:0]             op,
    input  logic [1:0]             sew,
    input  logic [$clog2(VLEN/8*MAX_GRP+1)-1:0] vl,
    input  logic [((MAX_GRP > 1) ? $clog2(MAX_GRP) : 1)-1:0] grp_m1,
    input  logic [XLEN-1:0]        offset,
    input  logic [XLEN-1:0]        scalar,
    input  logic [RF_AW-1:0]       vs_base,
    input  logic [RF_AW-1:0]       vd_base,
    output logic                   rd_en,
    output logic [RF_AW-1:0]       rd_addr,
    input  logic [VLEN-1:0]        rd_data,
    output logic                   wr_en,
    output logic [RF_AW-1:0]       wr_addr,
    output logic [VLEN/8-1:0]      wr_be,
    output logic [VLEN-1:0]        wr_data,
    output logic                   busy,
    output logic                   done
);
    localparam int VB   = VLEN / 8;
    localparam int BOFS = $clog2(VB);
    localparam int GW   = (MAX_GRP > 1) ? $clog2(MAX_GRP) : 1;
    localparam int VLW  = $clog2(VB * MAX_GRP + 1);
    localparam int PW   = $clog2(VB * MAX_GRP) + 2;

    typedef struct packed {
        slide_op_e        op;
        logic [1:0]       sew;
        logic [VLW-1:0]   vl;
        logic [GW-1:0]    grp;
        logic [VLW-1:0]   kc;
        logic [XLEN-1:0]  scal;
        logic [RF_AW-1:0] vs;
        logic [RF_AW-1:0] vd;
    } cfg_t;

    typedef struct packed {
        phase_e          ph;
        logic [GW-1:0]   r;
        logic [VLEN-1:0] lo;
        logic [VLEN-1:0] hi;
        cfg_t            cfg;
    } state_t;

    state_t st_d, st_q;

    logic [PW-1:0]   shb;
    logic            up_dir;
    logic [GW-1:0]   lo_reg, hi_reg;
    logic            lo_ok, hi_ok;
    logic [BOFS-1:0] rot;
    logic [VLW-1:0]  off_clip;
    slide_op_e       op_in;

    always_comb begin
        shb    = PW'(st_q.cfg.kc) << st_q.cfg.sew;
        up_dir = (st_q.cfg.op == OP_UP) || (st_q.cfg.op == OP_UP1);
    end

    vslide_srcsel #(.VB(VB), .GW(GW), .PW(PW), .BOFS(BOFS)) u_srcsel (
        .r      (st_q.r),
        .grp    (st_q.cfg.grp),
        .shb    (shb),
        .up     (up_dir),
        .lo_reg (lo_reg),
        .hi_reg (hi_reg),
        .lo_ok  (lo_ok),
        .hi_ok  (hi_ok),
        .rot    (rot)
    );

    vslide_bytemux #(
        .VLEN(VLEN), .GW(GW), .PW(PW), .VLW(VLW), .XLEN(XLEN), .BOFS(BOFS)
    ) u_bytemux (
        .r    (st_q.r),
        .lo   (st_q.lo),
        .hi   (st_q.hi),
        .rot  (rot),
        .op   (st_q.cfg.op),
        .sew  (st_q.cfg.sew),
        .vl   (st_q.cfg.vl),
        .kc   (st_q.cfg.kc),
        .scal (st_q.cfg.scal),
        .be   (wr_be),
        .data (wr_data)
    );

    always_comb begin
        op_in    = slide_op_e'(op);
        off_clip = (offset >= XLEN'(vl)) ? vl : offset[VLW-1:0];
        st_d     = st_q;
        rd_en    = 1'b0;
        rd_addr  = '0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.cfg.op   = op_in;
                    st_d.cfg.sew  = sew;
                    st_d.cfg.vl   = vl;
                    st_d.cfg.grp  = grp_m1;
                    st_d.cfg.scal = scalar;
                    st_d.cfg.vs   = vs_base;
                    st_d.cfg.vd   = vd_base;
                    case (op_in)
                        OP_UP, OP_DOWN:   st_d.cfg.kc = off_clip;
                        OP_UP1, OP_DOWN1: st_d.cfg.kc = VLW'(1);
                        default:          st_d.cfg.kc = '0;
                    endcase
                    st_d.r  = '0;
                    st_d.ph = PH_RDLO;
                end
            end
            PH_RDLO: begin
                rd_en   = lo_ok;
                rd_addr = st_q.cfg.vs + RF_AW'(lo_reg);
                st_d.lo = lo_ok ? rd_data : '0;
                st_d.ph = PH_RDHI;
            end
            PH_RDHI: begin
                rd_en   = hi_ok;
                rd_addr = st_q.cfg.vs + RF_AW'(hi_reg);
                st_d.hi = hi_ok ? rd_data : '0;
                st_d.ph = PH_WR;
            end
            PH_WR: begin
                if (st_q.r == st_q.cfg.grp) begin
                    st_d.ph = PH_FIN;
                end else begin
                    st_d.r  = st_q.r + GW'(1);
                    st_d.ph = PH_RDLO;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        wr_en   = (st_q.ph == PH_WR);
        wr_addr = st_q.cfg.vd + RF_AW'(st_q.r);
        busy    = (st_q.ph == PH_RDLO) || (st_q.ph == PH_RDHI) || (st_q.ph == PH_WR);
        done    = (st_q.ph == PH_FIN);
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: never two writes in adjacent cycles
    a_r11_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R11: each later write targets the next register up
    a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.r != '0) |-> (wr_addr == $past(wr_addr, 3) + RF_AW'(1)));

    // R1: an idle unit makes no register-file access
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !rd_en));

    // R8: a shift up by vl or more enables no byte
    a_r8_far_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.cfg.op == OP_UP && st_q.cfg.kc == st_q.cfg.vl) |-> (wr_be == '0));

    // R7: an empty vector writes nothing
    a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.cfg.vl == '0) |-> (wr_be == '0));

    // R4: scalar lands in the lowest byte of element 0
    a_r4_scalar_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.cfg.op == OP_UP1 && st_q.r == '0 && st_q.cfg.vl != '0)
        |-> (wr_be[0] && wr_data[7:0] == st_q.cfg.scal[7:0]));
endmodule

// File: tb/vslide_unit_test.sv
module vslide_unit_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [2:0]   op;
    logic [1:0]   sew;
    logic [7:0]   vl;
    logic [2:0]   grp_m1;
    logic [31:0]  offset;
    logic [31:0]  scalar;
    logic [4:0]   vs_base, vd_base;
    logic         rd_en, wr_en, busy, done;
    logic [4:0]   rd_addr, wr_addr;
    logic [127:0] rd_data, wr_data;
    logic [15:0]  wr_be;

    logic [127:0] rf     [32];
    logic [127:0] exp_rf [32];

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    vslide_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sew(sew), .vl(vl),
        .grp_m1(grp_m1), .offset(offset), .scalar(scalar), .vs_base(vs_base),
        .vd_base(vd_base), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    assign rd_data = rf[rd_addr];

    always @(posedge clk) begin
        if (wr_en)
            for (int j = 0; j < 16; j++)
                if (wr_be[j]) rf[wr_addr][j*8 +: 8] <= wr_data[j*8 +: 8];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic fill(input int salt);
        for (int a = 0; a < 32; a++)
            for (int n = 0; n < 16; n++)
                rf[a][n*8 +: 8] = 8'((a * 16 + n) * 7 + salt);
    endtask

    function automatic logic [31:0] get_el(input int base, input int i, input int eb);
        logic [31:0] v = '0;
        for (int k = 0; k < eb; k++) begin
            int bi = i * eb + k;
            v[k*8 +: 8] = rf[base + bi / 16][(bi % 16) * 8 +: 8];
        end
        return v;
    endfunction

    task automatic put_el(input int base, input int i, input int eb, input logic [31:0] v);
        for (int k = 0; k < eb; k++) begin
            int bi = i * eb + k;
            exp_rf[base + bi / 16][(bi % 16) * 8 +: 8] = v[k*8 +: 8];
        end
    endtask

    task automatic run_op(input int o, input int sw, input int vlv, input int gm1,
                          input longint off, input logic [31:0] sc, input int vs,
                          input int vd, input string tag, input bit poke);
        int eb = 1 << sw;
        int g  = gm1 + 1;
        logic [31:0] msk = (eb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * eb)) - 32'h1);
        bit seen = 1'b0;
        for (int a = 0; a < 32; a++) exp_rf[a] = rf[a];
        for (int i = 0; i < vlv; i++) begin
            logic [31:0] v;
            bit wr = 1'b1;
            case (o)
                1: if (i < off) wr = 1'b0; else v = get_el(vs, i - int'(off), eb);
                2: v = (i + off < vlv) ? get_el(vs, i + int'(off), eb) : 32'h0;
                3: v = (i == 0) ? (sc & msk) : get_el(vs, i - 1, eb);
                4: v = (i == vlv - 1) ? (sc & msk) : get_el(vs, i + 1, eb);
                default: v = get_el(vs, i, eb);
            endcase
            if (wr) put_el(vd, i, eb, v);
        end
        @(negedge clk);
        op = 3'(o); sew = 2'(sw); vl = 8'(vlv); grp_m1 = 3'(gm1);
        offset = 32'(off); scalar = sc; vs_base = 5'(vs); vd_base = 5'(vd);
        start = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= 3 * g + 4; c++) begin
            @(negedge clk);
            if (c == 0) start = 1'b0;
            if (poke && c == 2) begin start = 1'b1; op = 3'd2; offset = 32'd3; end
            if (poke && c == 3) start = 1'b0;
            // R10: busy for 3*G cycles, then one done cycle
            chk(busy == (c < 3 * g), {tag, "/R10"}, $sformatf("busy c=%0d", c),
                128'(busy), 128'(c < 3 * g));
            chk(done == (c == 3 * g), {tag, "/R10"}, $sformatf("done c=%0d", c),
                128'(done), 128'(c == 3 * g));
            if (c == 3 * g) begin seen = 1'b1; break; end
        end
        if (!seen) chk(1'b0, {tag, "/R10"}, "watchdog: no completion", 0, 1);
        @(negedge clk);
        chk(!busy && !done, {tag, "/R10"}, "back to idle", {busy, done}, 0);
        for (int a = 0; a < 32; a++)
            chk(rf[a] === exp_rf[a], tag, $sformatf("reg %0d", a), rf[a], exp_rf[a]);
    endtask

    initial begin
        #(20ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op = '0; sew = '0; vl = '0; grp_m1 = '0;
        offset = '0; scalar = '0; vs_base = '0; vd_base = '0;
        fill(3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en && !rd_en, "R1", "reset outputs",
            {busy, done, wr_en, rd_en}, 0);

        run_op(0, 0, 40, 3, 0, 32'h0, 0, 16, "R6", 1'b0);
        fill(11);
        run_op(1, 1, 30, 3, 5, 32'h0, 0, 16, "R2_R9", 1'b0);
        fill(29);
        run_op(2, 2, 29, 7, 3, 32'h0, 0, 16, "R3_R9", 1'b0);
        fill(41);
        run_op(3, 0, 128, 7, 0, 32'hA5C3_7E19, 0, 16, "R4", 1'b0);
        fill(53);
        run_op(4, 1, 15, 1, 0, 32'h1234_BEEF, 2, 20, "R5_R7", 1'b0);
        fill(67);
        run_op(1, 0, 50, 3, 200, 32'h0, 0, 16, "R8", 1'b0);
        fill(71);
        run_op(2, 0, 16, 0, 16, 32'h0, 4, 9, "R8", 1'b0);
        fill(83);
        run_op(2, 0, 100, 7, 37, 32'h0, 0, 16, "R3", 1'b0);
        fill(97);
        run_op(1, 2, 10, 3, 0, 32'h0, 0, 16, "R2_R9", 1'b0);
        fill(101);
        run_op(0, 2, 7, 1, 0, 32'h0, 0, 16, "R10_R6", 1'b1);
        fill(113);
        run_op(4, 2, 1, 0, 0, 32'hCAFE_F00D, 0, 16, "R5", 1'b0);
        fill(127);
        run_op(3, 0, 0, 1, 0, 32'h5A5A_5A5A, 0, 16, "R7", 1'b0);
        fill(131);
        run_op(1, 1, 64, 7, 13, 32'h0, 8, 24, "R2_R11", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule